// File: doc/BRIEF.md
# Update-Less Boundary Scan Chain

This block is a serial scan chain wrapped around the functional input and output pins of a processor core. Each cell has one serial flip-flop and one multiplexer. Input cells sit between the system and the core's inputs. Output cells sit between the core's outputs and the system.

A capture pulse loads every input cell with the system-side value and every output cell with the core's output. A shift pulse then moves the whole chain one position toward the serial output while fresh bits enter at the serial input. A TAP-style controller outside the block supplies capture, shift and a two-bit mode code. The mode code chooses whether the core and the system see the functional signals or the serial bits.

There is no update stage. Whenever a cell's multiplexer selects its serial bit, the functional pin follows that bit as it changes during shifting. Logic on the far side must tolerate a new value on every scan clock.

Top module: `scan_ring`

## Requirements
- R1: While reset is asserted and after its release, every serial bit is 0, so scan_out reads 0, and the mode is SYSTEM.
- R2: A capture loads cell i with sys_in[i] for i < N_IN and loads cell N_IN+j with core_out[j]. The result is visible on the cycle after the capture edge.
- R3: A shift (shf_en=1, cap_en=0) moves cell i into cell i+1 and loads scan_in into cell 0. scan_out always shows cell N_IN+N_OUT-1.
- R4: When cap_en and shf_en are both 1 on the same edge, the capture is performed and no shift occurs.
- R5: When cap_en and shf_en are both 0, every serial bit keeps its value.
- R6: In SYSTEM mode (code 2'b00), core_in equals sys_in and sys_out equals core_out.
- R7: In INTEST mode (code 2'b01), core_in[i] equals serial cell i and sys_out equals core_out.
- R8: In EXTEST mode (code 2'b10), sys_out[j] equals serial cell N_IN+j and core_in equals sys_in.
- R9: mode_sel is registered on each clock edge, so a new code takes effect one cycle after it is presented. Code 2'b11 behaves like SYSTEM.
- R10: There is no update latch. A pin whose multiplexer selects its serial bit changes in the same cycle that a shift changes that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| cap_en | input | 1 | Capture strobe; has priority over shf_en |
| shf_en | input | 1 | Shift strobe |
| mode_sel | input | 2 | 00 SYSTEM, 01 INTEST, 10 EXTEST, 11 treated as SYSTEM |
| scan_in | input | 1 | Serial input into cell 0 |
| scan_out | output | 1 | Serial output from the last cell |
| sys_in | input | N_IN | System-side values meant for the core |
| core_in | output | N_IN | Values applied to the core's inputs |
| core_out | input | N_OUT | Values produced by the core |
| sys_out | output | N_OUT | Values applied to the system |

## Verification
Directed sequences show each mode in turn:
- A capture, then holding, tells a capture from a shift.
- A simultaneous capture and shift shows which of the two wins.
- Shifting in INTEST and then in EXTEST shows the selected pins following the chain on every clock, which sets this block apart from a latched design.
- Code 11 and the one-cycle mode latency are probed directly.

Random strobes, random modes and random pin values then run against a cycle model of the chain in the bench. Any swap of cell order, of the priority between strobes, or of the mode encoding shows up as a mismatch on core_in, sys_out or scan_out.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    MODE_SYSTEM = 2'b00,
    MODE_INTEST = 2'b01,
    MODE_EXTEST = 2'b10,
    MODE_RSVD   = 2'b11
  } scan_mode_e;

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/scan_chain_reg.sv
module scan_chain_reg #(
  parameter int N_IN  = 64,
  parameter int N_OUT = 41,
  localparam int LEN  = N_IN + N_OUT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           shf_en,
  input  logic           ser_in,
  input  logic [LEN-1:0] cap_data,
  output logic [LEN-1:0] bits_q
);

  logic [LEN-1:0] bits_d;
  logic           load_en;

  // capture outranks shift; neither means hold
  always_comb begin
    load_en = cap_en | shf_en;
    if (cap_en) bits_d = cap_data;
    else        bits_d = {bits_q[LEN-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (load_en) bits_q <= bits_d;
  end

  // R2 R4
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (bits_q == $past(cap_data)));

  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_en && !cap_en) |=> ((bits_q[0] == $past(ser_in)) &&
                             (bits_q[LEN-1:1] == $past(bits_q[LEN-2:0]))));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shf_en && !cap_en) |=> $stable(bits_q));

endmodule

// File: rtl/scan_pin_mux.sv
module scan_pin_mux #(
  parameter int N_IN  = 64,
  parameter int N_OUT = 41
) (
  input  scan_pkg::scan_mode_e mode,
  input  logic [N_IN-1:0]      sys_in,
  input  logic [N_IN-1:0]      ser_in_cells,
  input  logic [N_OUT-1:0]     core_out,
  input  logic [N_OUT-1:0]     ser_out_cells,
  output logic [N_IN-1:0]      core_in,
  output logic [N_OUT-1:0]     sys_out
);
  import scan_pkg::*;

  logic drive_core;
  logic drive_sys;

  always_comb begin
    drive_core = (mode == MODE_INTEST);
    drive_sys  = (mode == MODE_EXTEST);
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
    assign core_in[i] = drive_core ? ser_in_cells[i] : sys_in[i];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_cell
    assign sys_out[j] = drive_sys ? ser_out_cells[j] : core_out[j];
  end

endmodule

// File: rtl/scan_ring.sv
module scan_ring #(
  parameter int N_IN  = 64,
  parameter int N_OUT = 41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             shf_en,
  input  logic [1:0]       mode_sel,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_IN-1:0]  sys_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] sys_out
);
  import scan_pkg::*;

  localparam int LEN = N_IN + N_OUT;

  logic           rst_q_n;
  logic [LEN-1:0] cells_q;
  scan_mode_e     mode_q;
  scan_mode_e     mode_d;

  scan_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // reserved code folds onto SYSTEM
  always_comb begin
    mode_d = scan_mode_e'(mode_sel);
    if (mode_d == MODE_RSVD) mode_d = MODE_SYSTEM;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) mode_q <= MODE_SYSTEM;
    else          mode_q <= mode_d;
  end

  scan_chain_reg #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chain (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cap_en   (cap_en),
    .shf_en   (shf_en),
    .ser_in   (scan_in),
    .cap_data ({core_out, sys_in}),
    .bits_q   (cells_q)
  );

  scan_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
    .mode          (mode_q),
    .sys_in        (sys_in),
    .ser_in_cells  (cells_q[N_IN-1:0]),
    .core_out      (core_out),
    .ser_out_cells (cells_q[LEN-1:N_IN]),
    .core_in       (core_in),
    .sys_out       (sys_out)
  );

  assign scan_out = cells_q[LEN-1];

  // R10
  intest_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode_q == MODE_INTEST && mode_sel == 2'b01 && shf_en && !cap_en)
      |=> (core_in[0] == $past(scan_in)));

  // R8
  extest_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode_q == MODE_EXTEST && mode_sel == 2'b10 && shf_en && !cap_en)
      |=> (sys_out[0] == $past(cells_q[N_IN-1])));

endmodule

// File: tb/scan_ring_tb.sv
module scan_ring_tb_top;

  localparam int N_IN  = 64;
  localparam int N_OUT = 41;
  localparam int LEN   = N_IN + N_OUT;

  logic             clk;
  logic             rst_n;
  logic             cap_en;
  logic             shf_en;
  logic [1:0]       mode_sel;
  logic             scan_in;
  logic             scan_out;
  logic [N_IN-1:0]  sys_in;
  logic [N_IN-1:0]  core_in;
  logic [N_OUT-1:0] core_out;
  logic [N_OUT-1:0] sys_out;

  int n_chk;
  int n_err;
  bit done;

  logic [LEN-1:0] m_cells;
  logic [1:0]     m_mode;

  scan_ring #(.N_IN(N_IN), .N_OUT(N_OUT)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .shf_en   (shf_en),
    .mode_sel (mode_sel),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .sys_in   (sys_in),
    .core_in  (core_in),
    .core_out (core_out),
    .sys_out  (sys_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [N_IN-1:0] exp_core_in(input logic [1:0] md,
      input logic [LEN-1:0] c, input logic [N_IN-1:0] si);
    return (md == 2'b01) ? c[N_IN-1:0] : si;
  endfunction

  function automatic logic [N_OUT-1:0] exp_sys_out(input logic [1:0] md,
      input logic [LEN-1:0] c, input logic [N_OUT-1:0] co);
    return (md == 2'b10) ? c[LEN-1:N_IN] : co;
  endfunction

  function automatic logic [LEN-1:0] next_cells(input logic [LEN-1:0] c,
      input logic cp, input logic sh, input logic si_bit,
      input logic [N_IN-1:0] si, input logic [N_OUT-1:0] co);
    if (cp)      return {co, si};
    else if (sh) return {c[LEN-2:0], si_bit};
    else         return c;
  endfunction

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'b01:   return "R7";
      2'b10:   return "R8";
      2'b11:   return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, check combinational result, then advance the model
  task automatic step(input logic cp, input logic sh, input logic [1:0] md,
                      input logic sbit, input logic [N_IN-1:0] si,
                      input logic [N_OUT-1:0] co, input string tag);
    string t;
    @(negedge clk);
    cap_en = cp; shf_en = sh; mode_sel = md; scan_in = sbit;
    sys_in = si; core_out = co;
    #1;
    t = (tag == "") ? mode_tag(m_mode) : tag;
    chk(t, "core_in",  128'(core_in),  128'(exp_core_in(m_mode, m_cells, si)));
    chk(t, "sys_out",  128'(sys_out),  128'(exp_sys_out(m_mode, m_cells, co)));
    chk(t, "scan_out", 128'(scan_out), 128'(m_cells[LEN-1]));
    m_cells = next_cells(m_cells, cp, sh, sbit, si, co);
    m_mode  = md;
  endtask

  function automatic logic [N_IN-1:0] rnd_in();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [N_OUT-1:0] rnd_out();
    return N_OUT'({$urandom(), $urandom()});
  endfunction

  initial begin
    #600000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [N_IN-1:0]  pat_a;
    logic [N_OUT-1:0] pat_b;
    void'($urandom(32'd20240611));
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; cap_en = 0; shf_en = 0; mode_sel = 2'b00; scan_in = 0;
    sys_in = '0; core_out = '0;
    m_cells = '0; m_mode = 2'b00;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "scan_out in reset", 128'(scan_out), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 after release: zeros and pass-through
    step(0, 0, 2'b00, 0, rnd_in(), rnd_out(), "R1");
    step(0, 0, 2'b01, 0, rnd_in(), rnd_out(), "R9");
    step(0, 0, 2'b01, 0, rnd_in(), rnd_out(), "R7");

    // R2 capture, then show captured bits in INTEST
    pat_a = 64'hA5C3_0F96_1234_8001;
    pat_b = 41'h1_5A5A_3C3C;
    step(1, 0, 2'b01, 0, pat_a, pat_b, "R7");
    step(0, 0, 2'b01, 0, rnd_in(), rnd_out(), "R2");
    chk("R2", "captured core_out top bit", 128'(scan_out), 128'(pat_b[N_OUT-1]));

    // R4 capture beats shift
    step(1, 1, 2'b01, 1, ~pat_a, ~pat_b, "R4");
    step(0, 0, 2'b01, 0, rnd_in(), rnd_out(), "R4");

    // R5 hold
    for (int k = 0; k < 6; k++) step(0, 0, 2'b01, 1, rnd_in(), rnd_out(), "R5");

    // R10 shifting in INTEST moves core_in every clock
    for (int k = 0; k < 8; k++) step(0, 1, 2'b01, 1'($urandom()), rnd_in(), rnd_out(), "R10");

    // EXTEST: shift with sys_out following the chain
    step(0, 0, 2'b10, 0, rnd_in(), rnd_out(), "R9");
    for (int k = 0; k < 8; k++) step(0, 1, 2'b10, 1'($urandom()), rnd_in(), rnd_out(), "R10");
    step(1, 0, 2'b10, 0, rnd_in(), rnd_out(), "R8");
    step(0, 0, 2'b10, 0, rnd_in(), rnd_out(), "R8");

    // R9 reserved code behaves like SYSTEM
    step(0, 0, 2'b11, 0, rnd_in(), rnd_out(), "R9");
    step(0, 0, 2'b11, 0, rnd_in(), rnd_out(), "R9");

    // R3 full shift-out after a capture
    step(1, 0, 2'b00, 0, pat_a, pat_b, "R6");
    for (int k = 0; k < LEN + 2; k++) step(0, 1, 2'b00, k[0], rnd_in(), rnd_out(), "R3");

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[3:0] == 0, r[4] | r[5], r[7:6], r[8], rnd_in(), rnd_out(), "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule